// File: doc/BRIEF.md
# DSP Single-Transfer Load/Store Unit

This block executes one 16-bit single-data-transfer instruction per clock for a DSP datapath. It holds four 32-bit address pointers and sixteen 32-bit data registers. Each accepted instruction names one pointer, one data register, an addressing mode and a transfer kind. The block forms the effective memory address, issues a single memory request, moves a word (16 bits) or a longword (32 bits) between memory and the data register, and updates the pointer as the mode requires.

The memory port is a plain combinational request: address, write enable, size and write data are valid in the same cycle as the instruction. Read data must be returned in that same cycle, and it is captured at the closing clock edge. Data registers 14 and 15 are guard registers. When either one is the source of a store, the stored value comes from an 8-bit guard bus and is sign-extended, not taken from the register file. A pointer increment can come from an external index value, so the block walks strided buffers without extra instructions.

Top module: `dsp_xfer_unit`

## Requirements
- R1: An instruction is executed only when `insn_valid` is high and `insn[15:10]` equals 6'b111101. Any other cycle raises no memory request and changes no pointer or data register.
- R2: `insn[9:8]` picks the pointer and `insn[7:4]` picks the data register. `insn[1:0]` picks the kind: 00 word load, 01 word store, 10 longword load, 11 longword store. `mem_size` is 0 for word and 1 for longword. `mem_we` is 1 for stores.
- R3: `insn[3:2]`=00 (pre-decrement) subtracts 2 (word) or 4 (longword) from the pointer. The result is both the access address and the new pointer value.
- R4: `insn[3:2]`=01 (plain indirect) accesses at the pointer and leaves the pointer unchanged.
- R5: `insn[3:2]`=10 (post-increment) accesses at the pointer, then adds 2 (word) or 4 (longword) to it.
- R6: `insn[3:2]`=11 (indexed post-increment) accesses at the pointer, then adds `index_val` to it, whatever the transfer size.
- R7: A word load takes `mem_rdata[15:0]`, writes it into bits [31:16] of the data register and clears bits [15:0].
- R8: A word store drives bits [31:16] of the source value on `mem_wdata[15:0]`, with `mem_wdata[31:16]` zero.
- R9: A longword load writes all 32 bits of `mem_rdata` into the data register. A longword store drives all 32 bits of the source value.
- R10: For a store whose source is data register 14 or 15, the source value is the sign-extended byte on `guard0_byte` or `guard1_byte`. This applies whatever was loaded into that register. The word or longword formatting of R8/R9 then applies.
- R11: Every instruction completes in one cycle. The request is issued in the instruction's cycle, and its register updates are visible to the next instruction.
- R12: After reset all pointers and data registers are zero. All address arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid | input | 1 | Instruction strobe |
| insn | input | 16 | Transfer instruction |
| index_val | input | 32 | Index increment for the indexed mode |
| guard0_byte | input | 8 | Guard byte for data register 14 |
| guard1_byte | input | 8 | Guard byte for data register 15 |
| mem_req | output | 1 | Memory request this cycle |
| mem_we | output | 1 | Write (store) request |
| mem_size | output | 1 | 0 word, 1 longword |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Load data, returned in the request cycle |

## Verification
Request outputs (`mem_req`, `mem_we`, `mem_size`, `mem_addr`, `mem_wdata`) depend combinationally on the instruction and the current registers. They are due in the cycle the instruction is applied. The bench drives each instruction on a falling edge and samples 1 ns later, before the rising edge. Pointer and data-register effects land on the following rising edge. The bench never reads them directly. It issues a later instruction, a plain-indirect access to show a pointer or a longword store to show a data register, and compares that instruction's request. Cycles in which nothing should execute are followed by such an observation before any other change.

// File: rtl/dsp_xfer_pkg.sv
package dsp_xfer_pkg;

   localparam logic [5:0] XFER_OPCODE = 6'b111101;

   typedef enum logic [1:0] {
      MODE_PRE  = 2'b00,
      MODE_IND  = 2'b01,
      MODE_POST = 2'b10,
      MODE_IDX  = 2'b11
   } xfer_mode_e;

   typedef enum logic [1:0] {
      OP_WLOAD  = 2'b00,
      OP_WSTORE = 2'b01,
      OP_LLOAD  = 2'b10,
      OP_LSTORE = 2'b11
   } xfer_op_e;

endpackage

// File: rtl/dsp_xfer_decode.sv
module dsp_xfer_decode
   import dsp_xfer_pkg::*;
#(
   parameter int AREG_W = 2,
   parameter int DREG_W = 4
) (
   input  logic              insn_valid,
   input  logic [15:0]       insn,
   output logic              hit,
   output logic [AREG_W-1:0] a_idx,
   output logic [DREG_W-1:0] d_idx,
   output xfer_mode_e        mode,
   output logic              is_store,
   output logic              is_long
);
   xfer_op_e op;

   always_comb begin
      hit      = insn_valid && (insn[15:10] == XFER_OPCODE);
      a_idx    = insn[8 +: AREG_W];
      d_idx    = insn[4 +: DREG_W];
      mode     = xfer_mode_e'(insn[3:2]);
      op       = xfer_op_e'(insn[1:0]);
      is_store = (op == OP_WSTORE) || (op == OP_LSTORE);
      is_long  = (op == OP_LLOAD)  || (op == OP_LSTORE);
   end

endmodule

// File: rtl/dsp_xfer_agu.sv
module dsp_xfer_agu
   import dsp_xfer_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic [ADDR_W-1:0] ptr_cur,
   input  logic [ADDR_W-1:0] index_val,
   input  xfer_mode_e        mode,
   input  logic              is_long,
   output logic [ADDR_W-1:0] acc_addr,
   output logic [ADDR_W-1:0] ptr_next,
   output logic              ptr_upd
);
   localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(DATA_W / 16);
   localparam logic [ADDR_W-1:0] LONG_STEP = ADDR_W'(DATA_W / 8);

   logic [ADDR_W-1:0] step;
   logic [ADDR_W-1:0] dec_val;

   always_comb begin
      step     = is_long ? LONG_STEP : WORD_STEP;
      dec_val  = ptr_cur - step;
      acc_addr = ptr_cur;
      ptr_next = ptr_cur;
      ptr_upd  = 1'b1;
      unique case (mode)
         MODE_PRE: begin
            acc_addr = dec_val;
            ptr_next = dec_val;
         end
         MODE_IND:  ptr_upd  = 1'b0;
         MODE_POST: ptr_next = ptr_cur + step;
         MODE_IDX:  ptr_next = ptr_cur + index_val;
         default:   ptr_upd  = 1'b0;
      endcase
   end

endmodule

// File: rtl/dsp_xfer_regfile.sv
module dsp_xfer_regfile #(
   parameter int ENTRIES = 4,
   parameter int WIDTH   = 32,
   parameter int IDX_W   = $clog2(ENTRIES)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [IDX_W-1:0]         wr_idx,
   input  logic [WIDTH-1:0]         wr_val,
   input  logic [IDX_W-1:0]         rd_idx,
   output logic [WIDTH-1:0]         rd_val,
   output logic [ENTRIES*WIDTH-1:0] all_flat
);
   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      logic [WIDTH-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (wr_en && (wr_idx == IDX_W'(e)))
            q <= wr_val;
      end
      assign all_flat[e*WIDTH +: WIDTH] = q;
   end

   assign rd_val = all_flat[rd_idx*WIDTH +: WIDTH];

endmodule

// File: rtl/dsp_xfer_format.sv
module dsp_xfer_format #(
   parameter int DATA_W   = 32,
   parameter int DREG_W   = 4,
   parameter int GUARD_W  = 8,
   parameter bit GUARD_EN = 1'b1,
   parameter int G0_IDX   = 14,
   parameter int G1_IDX   = 15
) (
   input  logic [DREG_W-1:0]  d_idx,
   input  logic [DATA_W-1:0]  dreg_val,
   input  logic [GUARD_W-1:0] guard0_byte,
   input  logic [GUARD_W-1:0] guard1_byte,
   input  logic               is_long,
   input  logic [DATA_W-1:0]  mem_rdata,
   output logic [DATA_W-1:0]  store_val,
   output logic [DATA_W-1:0]  load_val
);
   localparam int HALF = DATA_W / 2;
   localparam int EXT  = DATA_W - GUARD_W;

   logic [DATA_W-1:0] src_val;

   if (GUARD_EN) begin : g_guard
      logic [DATA_W-1:0] g0_ext;
      logic [DATA_W-1:0] g1_ext;
      assign g0_ext = {{EXT{guard0_byte[GUARD_W-1]}}, guard0_byte};
      assign g1_ext = {{EXT{guard1_byte[GUARD_W-1]}}, guard1_byte};
      always_comb begin
         if (d_idx == DREG_W'(G0_IDX))
            src_val = g0_ext;
         else if (d_idx == DREG_W'(G1_IDX))
            src_val = g1_ext;
         else
            src_val = dreg_val;
      end
   end else begin : g_plain
      logic unused_guard;
      assign unused_guard = ^{guard0_byte, guard1_byte};
      assign src_val      = dreg_val;
   end

   always_comb begin
      if (is_long) begin
         store_val = src_val;
         load_val  = mem_rdata;
      end else begin
         store_val = {{HALF{1'b0}}, src_val[DATA_W-1:HALF]};
         load_val  = {mem_rdata[HALF-1:0], {HALF{1'b0}}};
      end
   end

endmodule

// File: rtl/dsp_xfer_unit.sv
module dsp_xfer_unit
   import dsp_xfer_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 32,
   parameter int N_AREG   = 4,
   parameter int N_DREG   = 16,
   parameter int GUARD_W  = 8,
   parameter bit GUARD_EN = 1'b1,
   parameter int G0_IDX   = 14,
   parameter int G1_IDX   = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              insn_valid,
   input  logic [15:0]       insn,
   input  logic [31:0]       index_val,
   input  logic [7:0]        guard0_byte,
   input  logic [7:0]        guard1_byte,
   output logic              mem_req,
   output logic              mem_we,
   output logic              mem_size,
   output logic [31:0]       mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic [31:0]       mem_rdata
);
   localparam int AREG_W = $clog2(N_AREG);
   localparam int DREG_W = $clog2(N_DREG);

   if (N_AREG != 4)             begin : g_bad_areg  $error("N_AREG must be 4");        end
   if (N_DREG != 16)            begin : g_bad_dreg  $error("N_DREG must be 16");       end
   if (ADDR_W != 32)            begin : g_bad_addr  $error("ADDR_W must be 32");       end
   if (DATA_W != 32)            begin : g_bad_data  $error("DATA_W must be 32");       end
   if (GUARD_W != 8)            begin : g_bad_guard $error("GUARD_W must be 8");       end
   if (G0_IDX >= N_DREG || G1_IDX >= N_DREG || G0_IDX == G1_IDX)
                                begin : g_bad_gidx  $error("bad guard indices");       end

   logic              hit;
   logic [AREG_W-1:0] a_idx;
   logic [DREG_W-1:0] d_idx;
   xfer_mode_e        mode;
   logic              is_store;
   logic              is_long;

   logic [ADDR_W-1:0] ptr_cur;
   logic [ADDR_W-1:0] ptr_next;
   logic [ADDR_W-1:0] acc_addr;
   logic              ptr_upd;
   logic [DATA_W-1:0] dreg_val;
   logic [DATA_W-1:0] store_val;
   logic [DATA_W-1:0] load_val;

   logic [N_AREG*ADDR_W-1:0] areg_flat;
   logic [N_DREG*DATA_W-1:0] dreg_flat;

   dsp_xfer_decode #(.AREG_W(AREG_W), .DREG_W(DREG_W)) i_decode (
      .insn_valid (insn_valid),
      .insn       (insn),
      .hit        (hit),
      .a_idx      (a_idx),
      .d_idx      (d_idx),
      .mode       (mode),
      .is_store   (is_store),
      .is_long    (is_long)
   );

   dsp_xfer_regfile #(.ENTRIES(N_AREG), .WIDTH(ADDR_W)) i_aregs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (hit && ptr_upd),
      .wr_idx   (a_idx),
      .wr_val   (ptr_next),
      .rd_idx   (a_idx),
      .rd_val   (ptr_cur),
      .all_flat (areg_flat)
   );

   dsp_xfer_agu #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_agu (
      .ptr_cur   (ptr_cur),
      .index_val (index_val),
      .mode      (mode),
      .is_long   (is_long),
      .acc_addr  (acc_addr),
      .ptr_next  (ptr_next),
      .ptr_upd   (ptr_upd)
   );

   dsp_xfer_regfile #(.ENTRIES(N_DREG), .WIDTH(DATA_W)) i_dregs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (hit && !is_store),
      .wr_idx   (d_idx),
      .wr_val   (load_val),
      .rd_idx   (d_idx),
      .rd_val   (dreg_val),
      .all_flat (dreg_flat)
   );

   dsp_xfer_format #(
      .DATA_W   (DATA_W),
      .DREG_W   (DREG_W),
      .GUARD_W  (GUARD_W),
      .GUARD_EN (GUARD_EN),
      .G0_IDX   (G0_IDX),
      .G1_IDX   (G1_IDX)
   ) i_format (
      .d_idx       (d_idx),
      .dreg_val    (dreg_val),
      .guard0_byte (guard0_byte),
      .guard1_byte (guard1_byte),
      .is_long     (is_long),
      .mem_rdata   (mem_rdata),
      .store_val   (store_val),
      .load_val    (load_val)
   );

   always_comb begin
      mem_req   = hit;
      mem_we    = hit && is_store;
      mem_size  = hit && is_long;
      mem_addr  = hit ? acc_addr : '0;
      mem_wdata = (hit && is_store) ? store_val : '0;
   end

endmodule

// File: rtl/dsp_xfer_checks.sv
module dsp_xfer_checks #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int N_AREG = 4,
   parameter int N_DREG = 16
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     insn_valid,
   input logic [15:0]              insn,
   input logic [31:0]              index_val,
   input logic                     mem_req,
   input logic                     mem_we,
   input logic                     mem_size,
   input logic [31:0]              mem_addr,
   input logic [31:0]              mem_wdata,
   input logic [31:0]              mem_rdata,
   input logic [N_AREG*ADDR_W-1:0] areg_flat,
   input logic [N_DREG*DATA_W-1:0] dreg_flat
);
   localparam int HALF = DATA_W / 2;

   function automatic logic [ADDR_W-1:0] ptr_of(input logic [N_AREG*ADDR_W-1:0] f,
                                                input logic [1:0] i);
      return f[i*ADDR_W +: ADDR_W];
   endfunction

   function automatic logic [DATA_W-1:0] reg_of(input logic [N_DREG*DATA_W-1:0] f,
                                                input logic [3:0] i);
      return f[i*DATA_W +: DATA_W];
   endfunction

   a_r1_foreign_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (insn[15:10] != 6'b111101) |-> !mem_req);

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !insn_valid |-> !mem_req);

   a_r1_idle_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_req |=> (areg_flat == $past(areg_flat)) && (dreg_flat == $past(dreg_flat)));

   a_r2_kind_decode: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_size == insn[1]) && (mem_we == insn[0]));

   a_r3_predec_ptr: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && insn[3:2] == 2'b00) |=>
         ptr_of(areg_flat, $past(insn[9:8])) == $past(mem_addr));

   a_r4_plain_ptr: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && insn[3:2] == 2'b01) |=>
         ptr_of(areg_flat, $past(insn[9:8])) == $past(mem_addr));

   a_r5_postinc_ptr: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && insn[3:2] == 2'b10) |=>
         ptr_of(areg_flat, $past(insn[9:8])) ==
            $past(mem_addr) + ($past(insn[1]) ? ADDR_W'(DATA_W / 8) : ADDR_W'(DATA_W / 16)));

   a_r6_index_ptr: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && insn[3:2] == 2'b11) |=>
         ptr_of(areg_flat, $past(insn[9:8])) == $past(mem_addr) + $past(index_val));

   a_r7_word_load_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && insn[1:0] == 2'b00) |=>
         reg_of(dreg_flat, $past(insn[7:4])) == {$past(mem_rdata[HALF-1:0]), {HALF{1'b0}}});

   a_r8_word_store_upper: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && insn[1:0] == 2'b01) |-> mem_wdata[DATA_W-1:HALF] == '0);

   a_r9_long_load_full: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && insn[1:0] == 2'b10) |=>
         reg_of(dreg_flat, $past(insn[7:4])) == $past(mem_rdata));

endmodule

bind dsp_xfer_unit dsp_xfer_checks #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .N_AREG (N_AREG),
   .N_DREG (N_DREG)
) i_checks (
   .clk        (clk),
   .rst_n      (rst_n),
   .insn_valid (insn_valid),
   .insn       (insn),
   .index_val  (index_val),
   .mem_req    (mem_req),
   .mem_we     (mem_we),
   .mem_size   (mem_size),
   .mem_addr   (mem_addr),
   .mem_wdata  (mem_wdata),
   .mem_rdata  (mem_rdata),
   .areg_flat  (areg_flat),
   .dreg_flat  (dreg_flat)
);

// File: tb/test_dsp_xfer_unit.sv
module test_dsp_xfer_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        insn_valid = 1'b0;
   logic [15:0] insn = 16'h0;
   logic [31:0] index_val = 32'h0;
   logic [7:0]  guard0_byte = 8'h0;
   logic [7:0]  guard1_byte = 8'h0;
   logic        mem_req, mem_we, mem_size;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;

   logic        pre_en = 1'b0;
   logic [6:0]  pre_a = 7'h0;
   logic [15:0] pre_d = 16'h0;
   logic [15:0] mem16 [0:127];

   int checks = 0;
   int failures = 0;

   logic        c_req, c_we, c_size;
   logic [31:0] c_addr, c_wdata;

   localparam logic [1:0] PRE = 2'b00, IND = 2'b01, POST = 2'b10, IDX = 2'b11;
   localparam logic [1:0] WLD = 2'b00, WST = 2'b01, LLD = 2'b10, LST = 2'b11;

   always #2 clk = ~clk;

   dsp_xfer_unit i_dsp_xfer_unit (
      .clk         (clk),
      .rst_n       (rst_n),
      .insn_valid  (insn_valid),
      .insn        (insn),
      .index_val   (index_val),
      .guard0_byte (guard0_byte),
      .guard1_byte (guard1_byte),
      .mem_req     (mem_req),
      .mem_we      (mem_we),
      .mem_size    (mem_size),
      .mem_addr    (mem_addr),
      .mem_wdata   (mem_wdata),
      .mem_rdata   (mem_rdata)
   );

   // bench memory: 128 halfwords, address bits [7:1]
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < 128; k++) mem16[k] <= 16'h0;
      end else if (pre_en) begin
         mem16[pre_a] <= pre_d;
      end else if (mem_req && mem_we) begin
         if (mem_size) begin
            mem16[{mem_addr[7:2], 1'b0}] <= mem_wdata[15:0];
            mem16[{mem_addr[7:2], 1'b1}] <= mem_wdata[31:16];
         end else begin
            mem16[mem_addr[7:1]] <= mem_wdata[15:0];
         end
      end
   end

   always_comb begin
      if (mem_size)
         mem_rdata = {mem16[{mem_addr[7:2], 1'b1}], mem16[{mem_addr[7:2], 1'b0}]};
      else
         mem_rdata = {16'h0, mem16[mem_addr[7:1]]};
   end

   function automatic logic [15:0] mk(input logic [1:0] a, input logic [3:0] d,
                                      input logic [1:0] m, input logic [1:0] op);
      return {6'b111101, a, d, m, op};
   endfunction

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s actual=%08h expected=%08h", tag, got, exp);
      end
   endtask

   task automatic issue(input logic [15:0] w, input logic v);
      @(negedge clk);
      insn       = w;
      insn_valid = v;
      #1;
      c_req   = mem_req;
      c_we    = mem_we;
      c_size  = mem_size;
      c_addr  = mem_addr;
      c_wdata = mem_wdata;
      @(posedge clk);
      #1;
      insn_valid = 1'b0;
   endtask

   task automatic preset(input logic [6:0] a, input logic [15:0] d);
      @(negedge clk);
      pre_en = 1'b1;
      pre_a  = a;
      pre_d  = d;
      @(negedge clk);
      pre_en = 1'b0;
   endtask

   task automatic t_reset();
      issue(mk(2'd2, 4'd5, IND, LST), 1'b1);
      chk("R12 reset pointer zero", c_addr, 32'h0);
      chk("R12 reset data zero", c_wdata, 32'h0);
      chk("R2 longword store req/we/size", {29'h0, c_req, c_we, c_size}, 32'h7);
   endtask

   task automatic t_index();
      index_val = 32'h100;
      issue(mk(2'd1, 4'd0, IDX, LLD), 1'b1);
      chk("R6 index access at current", c_addr, 32'h0);
      chk("R2 longword load we/size", {30'h0, c_we, c_size}, 32'h1);
      issue(mk(2'd1, 4'd0, IND, LST), 1'b1);
      chk("R6 R11 pointer plus index", c_addr, 32'h100);
      index_val = 32'h10;
      issue(mk(2'd1, 4'd0, IDX, WLD), 1'b1);
      chk("R6 word index access", c_addr, 32'h100);
      chk("R2 word load we/size", {30'h0, c_we, c_size}, 32'h0);
      issue(mk(2'd1, 4'd0, IND, LST), 1'b1);
      chk("R6 index step ignores size", c_addr, 32'h110);
   endtask

   task automatic t_postinc();
      issue(mk(2'd1, 4'd2, POST, LST), 1'b1);
      chk("R5 long postinc access", c_addr, 32'h110);
      issue(mk(2'd1, 4'd2, IND, LST), 1'b1);
      chk("R5 R11 long postinc +4", c_addr, 32'h114);
      issue(mk(2'd1, 4'd2, POST, WST), 1'b1);
      chk("R5 word postinc access", c_addr, 32'h114);
      issue(mk(2'd1, 4'd2, IND, WST), 1'b1);
      chk("R5 word postinc +2", c_addr, 32'h116);
      chk("R4 plain keeps pointer", c_addr, 32'h116);
      issue(mk(2'd1, 4'd2, IND, WST), 1'b1);
      chk("R4 plain repeat same address", c_addr, 32'h116);
   endtask

   task automatic t_predec();
      issue(mk(2'd0, 4'd3, PRE, WLD), 1'b1);
      chk("R3 R12 word predec wraps", c_addr, 32'hFFFF_FFFE);
      issue(mk(2'd0, 4'd3, IND, WLD), 1'b1);
      chk("R3 predec pointer written", c_addr, 32'hFFFF_FFFE);
      issue(mk(2'd0, 4'd3, PRE, LLD), 1'b1);
      chk("R3 long predec -4", c_addr, 32'hFFFF_FFFA);
      index_val = 32'hA;
      issue(mk(2'd0, 4'd3, IDX, LLD), 1'b1);
      chk("R3 pointer after long predec", c_addr, 32'hFFFF_FFFA);
      issue(mk(2'd0, 4'd3, IND, LLD), 1'b1);
      chk("R12 index add wraps", c_addr, 32'h0000_0004);
   endtask

   task automatic t_data();
      preset(7'h22, 16'h5678);
      preset(7'h23, 16'h1234);
      preset(7'h21, 16'hBEEF);
      preset(7'h40, 16'h1234);
      preset(7'h41, 16'hCAFE);
      index_val = 32'h44;
      issue(mk(2'd3, 4'd1, IDX, LLD), 1'b1);
      issue(mk(2'd3, 4'd7, IND, LLD), 1'b1);
      issue(mk(2'd3, 4'd7, IND, LST), 1'b1);
      chk("R9 longword load/store", c_wdata, 32'h1234_5678);
      issue(mk(2'd3, 4'd7, PRE, WLD), 1'b1);
      chk("R3 word predec addr", c_addr, 32'h42);
      issue(mk(2'd3, 4'd7, IND, LST), 1'b1);
      chk("R7 word load fills upper clears lower", c_wdata, 32'hBEEF_0000);
      issue(mk(2'd3, 4'd7, IND, WST), 1'b1);
      chk("R8 word store data", c_wdata, 32'h0000_BEEF);
      chk("R8 word store size/we", {30'h0, c_we, c_size}, 32'h2);
      issue(mk(2'd3, 4'd9, IND, WLD), 1'b1);
      issue(mk(2'd3, 4'd9, IND, LST), 1'b1);
      chk("R7 R8 word round trip", c_wdata, 32'hBEEF_0000);
      index_val = 32'h3E;
      issue(mk(2'd3, 4'd1, IDX, LLD), 1'b1);
      issue(mk(2'd3, 4'd8, POST, LLD), 1'b1);
      chk("R6 index to 0x80", c_addr, 32'h80);
      issue(mk(2'd3, 4'd8, IND, WST), 1'b1);
      chk("R5 long postinc to 0x84", c_addr, 32'h84);
      chk("R8 word store takes upper half", c_wdata, 32'h0000_CAFE);
   endtask

   task automatic t_guard();
      guard0_byte = 8'h85;
      guard1_byte = 8'h7A;
      issue(mk(2'd2, 4'd14, IND, LST), 1'b1);
      chk("R10 guard0 negative sign-extend", c_wdata, 32'hFFFF_FF85);
      issue(mk(2'd2, 4'd15, IND, LST), 1'b1);
      chk("R10 guard1 positive sign-extend", c_wdata, 32'h0000_007A);
      issue(mk(2'd2, 4'd14, IND, WST), 1'b1);
      chk("R10 guard0 word store", c_wdata, 32'h0000_FFFF);
      issue(mk(2'd2, 4'd15, IND, WST), 1'b1);
      chk("R10 guard1 word store", c_wdata, 32'h0000_0000);
      issue(mk(2'd2, 4'd14, IND, LLD), 1'b1);
      issue(mk(2'd2, 4'd14, IND, LST), 1'b1);
      chk("R10 guard bus overrides loaded value", c_wdata, 32'hFFFF_FF85);
      guard0_byte = 8'h01;
      issue(mk(2'd2, 4'd14, IND, LST), 1'b1);
      chk("R10 guard bus followed live", c_wdata, 32'h0000_0001);
   endtask

   task automatic t_ignore();
      // memory at address 0 now holds 0x00000001 (last store)
      issue({6'b111100, 2'd2, 4'd5, POST, LLD}, 1'b1);
      chk("R1 foreign opcode no request", {31'h0, c_req}, 32'h0);
      issue({6'b111111, 2'd2, 4'd5, PRE, LLD}, 1'b1);
      chk("R1 foreign opcode 111111 no request", {31'h0, c_req}, 32'h0);
      issue(mk(2'd2, 4'd5, POST, LLD), 1'b0);
      chk("R1 invalid strobe no request", {31'h0, c_req}, 32'h0);
      issue(mk(2'd2, 4'd5, IND, LST), 1'b1);
      chk("R1 pointer unchanged", c_addr, 32'h0);
      chk("R1 data register unchanged", c_wdata, 32'h0);
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      failures++;
      $display("FAIL R11 watchdog actual=hung expected=done");
      summary();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_index();
      t_postinc();
      t_predec();
      t_data();
      t_guard();
      t_ignore();
      summary();
   end

endmodule